// File: doc/BRIEF.md
# Full-Bridge PWM Output Controller

This block turns a programmable period and duty setting into the four gate signals of an H-bridge. A free-running counter sets the period. In forward direction one diagonal of the bridge conducts: its high-side switch is held on and its low-side switch is modulated by the duty comparison. Reverse direction uses the other diagonal. Each of the two output pairs (A/C and B/D) has its own polarity, so the pins can match active-high or active-low gate drivers.

Because the pin drivers are off at power-up, the block holds all four output enables low after reset. It also keeps them low after the mode is switched on, until one whole PWM period has run. The end of the first period raises a sticky rollover flag, and software clears that flag with a write-one strobe. A direction request waits for the next period boundary. The newly selected diagonal then stays off for a programmable number of clock cycles. This lets the switches of the old diagonal finish turning off before the opposite switches turn on, which prevents shoot-through.

Top module: `fbridge_pwm`

## Requirements
- R1: After reset, `pwm_oe` is 4'b0000, `pwm_out` is 4'b0000 and `roll_flag` is 0.
- R2: While `mode_en` is 1, the counter steps 0,1,…,`cfg_period` and then returns to 0. The modulated output is active whenever the count is less than `cfg_duty`. A duty of 0 keeps it inactive, and a duty above the period keeps it active for the whole period.
- R3: `pwm_out` bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. In forward mode (`cfg_dir`=0), A is steadily active, D is modulated, and B and C are inactive. In reverse mode (`cfg_dir`=1), C is steadily active, B is modulated, and A and D are inactive. A and B are never active together, and neither are C and D.
- R4: A polarity bit of 1 makes that pair active-low, which inverts its pin values. `pol_ac` controls bits 0 and 2, and `pol_bd` controls bits 1 and 3. A `pol_wr` pulse loads both bits.
- R5: A `pol_wr` pulse while `pwm_oe` is nonzero is ignored.
- R6: After `mode_en` and `drv_req` are both 1, `pwm_oe` stays 4'b0000 until the clock edge at which the count wraps from `cfg_period` to 0. From the cycle after that edge, `pwm_oe` is 4'b1111.
- R7: `roll_flag` sets at every wrap from `cfg_period` to 0. It stays set until a cycle with `roll_clr`=1. If a set and a clear happen in the same cycle, the set wins.
- R8: When `drv_req` goes to 0, `pwm_oe` falls to 0 in the same cycle, with no clock edge needed. A later request waits again for the next wrap.
- R9: A change of `cfg_dir` takes effect only at a wrap. After that wrap, all logical outputs stay inactive for `cfg_deadtime` cycles, and then the new diagonal is driven.
- R10: While `mode_en` is 0, the counter is held at 0, all logical outputs are inactive and `pwm_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | CNT_W | Last count value of the period |
| cfg_duty | input | CNT_W | Modulated output active while count < this value |
| cfg_dir | input | 1 | Requested direction: 0 forward, 1 reverse |
| cfg_deadtime | input | DT_W | Idle cycles after a direction switch |
| pol_wr | input | 1 | Load strobe for the pair polarity bits |
| pol_ac | input | 1 | Pair A/C polarity, 1 = active-low |
| pol_bd | input | 1 | Pair B/D polarity, 1 = active-low |
| mode_en | input | 1 | Run the PWM timebase and steering |
| drv_req | input | 1 | Request to turn the pin drivers on |
| roll_clr | input | 1 | Write-one clear of the rollover flag |
| pwm_out | output | 4 | Pin values, bit 0..3 = A..D |
| pwm_oe | output | 4 | Pin output enables, bit 0..3 = A..D |
| roll_flag | output | 1 | Sticky period-rollover flag |

## Verification
The assertions assume that software keeps `cfg_period` steady while the timebase runs. The boundary check on direction changes also assumes that `mode_en` is not toggled in the same cycle as a direction change. The polarity-stability property depends on the rule that polarity can change only through `pol_wr` while the enables are low. The stimulus changes the period and the mode only while the counter is stopped. It drives direction, duty and polarity at negative clock edges, so each change is sampled cleanly at the following rising edge.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

    // Logical bridge state, packed so that bit 0 = A ... bit 3 = D
    typedef struct packed {
        logic d;
        logic c;
        logic b;
        logic a;
    } bridge_t;

    localparam bridge_t BRIDGE_IDLE = '{d: 1'b0, c: 1'b0, b: 1'b0, a: 1'b0};

    // Select the conducting diagonal: one steady high-side switch, one modulated low-side switch
    function automatic bridge_t diag_sel(dir_e dir, logic mod_on);
        bridge_t r;
        r = BRIDGE_IDLE;
        if (dir == DIR_FWD) begin
            r.a = 1'b1;
            r.d = mod_on;
        end else begin
            r.c = 1'b1;
            r.b = mod_on;
        end
        return r;
    endfunction

    // Apply per-pair inversion (A/C share one bit, B/D the other)
    function automatic bridge_t pair_invert(bridge_t l, logic inv_ac, logic inv_bd);
        bridge_t r;
        r.a = l.a ^ inv_ac;
        r.c = l.c ^ inv_ac;
        r.b = l.b ^ inv_bd;
        r.d = l.d ^ inv_bd;
        return r;
    endfunction

endpackage

// File: rtl/fbp_timebase.sv
module fbp_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] last_cnt,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             flag
);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    assign wrap = run && (cnt_q >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_q) && !$past(flag_clr)) |-> flag_q);

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> (cnt_q == '0));

endmodule

// File: rtl/fbp_startup.sv
module fbp_startup (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic req,
    input  logic wrap,
    output logic drv_on
);

    logic seen_full_q;

    always_ff @(posedge clk) begin
        if (rst || !run || !req) begin
            seen_full_q <= 1'b0;
        end else if (wrap) begin
            seen_full_q <= 1'b1;
        end
    end

    assign drv_on = seen_full_q && run && req;

    // R6
    drv_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_on) |-> $past(wrap));

endmodule

// File: rtl/fbp_steer.sv
module fbp_steer
    import fbp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    input  logic             dir_req,
    input  logic [DT_W-1:0]  dead_len,
    input  logic             pol_wr,
    input  logic             pol_ac,
    input  logic             pol_bd,
    input  logic             drv_on,
    output bridge_t          pins
);

    dir_e            dir_q;
    logic [DT_W-1:0] dead_q;
    logic            inv_ac_q;
    logic            inv_bd_q;
    logic            mod_on;
    bridge_t         logical;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_FWD;
            dead_q <= '0;
        end else if (!run) begin
            dir_q  <= dir_e'(dir_req);
            dead_q <= '0;
        end else if (wrap && (dir_e'(dir_req) != dir_q)) begin
            dir_q  <= dir_e'(dir_req);
            dead_q <= dead_len;
        end else if (dead_q != '0) begin
            dead_q <= dead_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_ac_q <= 1'b0;
            inv_bd_q <= 1'b0;
        end else if (pol_wr && !drv_on) begin
            inv_ac_q <= pol_ac;
            inv_bd_q <= pol_bd;
        end
    end

    assign mod_on = (cnt < duty);

    always_comb begin
        if (!run || (dead_q != '0)) begin
            logical = BRIDGE_IDLE;
        end else begin
            logical = diag_sel(dir_q, mod_on);
        end
    end

    assign pins = pair_invert(logical, inv_ac_q, inv_bd_q);

    // R5
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(drv_on) && drv_on) |-> ($stable(inv_ac_q) && $stable(inv_bd_q)));

    // R9
    dir_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && !$stable(dir_q)) |-> $past(wrap));

    // R3
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(logical.a && logical.b) && !(logical.c && logical.d));

endmodule

// File: rtl/fbridge_pwm.sv
module fbridge_pwm
    import fbp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    input  logic             cfg_dir,
    input  logic [DT_W-1:0]  cfg_deadtime,
    input  logic             pol_wr,
    input  logic             pol_ac,
    input  logic             pol_bd,
    input  logic             mode_en,
    input  logic             drv_req,
    input  logic             roll_clr,
    output logic [3:0]       pwm_out,
    output logic [3:0]       pwm_oe,
    output logic             roll_flag
);

    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             drv_on;
    bridge_t          pins;

    fbp_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_en),
        .last_cnt (cfg_period),
        .flag_clr (roll_clr),
        .cnt      (cnt),
        .wrap     (wrap),
        .flag     (roll_flag)
    );

    fbp_startup u_su (
        .clk    (clk),
        .rst    (rst),
        .run    (mode_en),
        .req    (drv_req),
        .wrap   (wrap),
        .drv_on (drv_on)
    );

    fbp_steer #(.CNT_W(CNT_W), .DT_W(DT_W)) u_st (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_en),
        .wrap     (wrap),
        .cnt      (cnt),
        .duty     (cfg_duty),
        .dir_req  (cfg_dir),
        .dead_len (cfg_deadtime),
        .pol_wr   (pol_wr),
        .pol_ac   (pol_ac),
        .pol_bd   (pol_bd),
        .drv_on   (drv_on),
        .pins     (pins)
    );

    assign pwm_out = pins;
    assign pwm_oe  = {4{drv_on}};

    // R8
    oe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_req |-> (pwm_oe == 4'b0000));

endmodule

// File: tb/tb_fbridge_pwm.sv
`timescale 1ns/1ps
module tb_fbridge_pwm;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] cfg_period;
    logic [7:0] cfg_duty;
    logic       cfg_dir;
    logic [3:0] cfg_deadtime;
    logic       pol_wr, pol_ac, pol_bd;
    logic       mode_en, drv_req, roll_clr;
    logic [3:0] pwm_out, pwm_oe;
    logic       roll_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;
    logic m_ac = 0, m_bd = 0;   // bench-tracked polarity

    always #2.5 clk = ~clk;

    fbridge_pwm dut (
        .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_duty(cfg_duty),
        .cfg_dir(cfg_dir), .cfg_deadtime(cfg_deadtime), .pol_wr(pol_wr),
        .pol_ac(pol_ac), .pol_bd(pol_bd), .mode_en(mode_en), .drv_req(drv_req),
        .roll_clr(roll_clr), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .roll_flag(roll_flag)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pinv(logic [3:0] lg);
        return lg ^ {m_bd, m_ac, m_bd, m_ac};
    endfunction

    task automatic t_reset();
        rst = 1; mode_en = 0; drv_req = 0; roll_clr = 0; pol_wr = 0;
        pol_ac = 0; pol_bd = 0; cfg_dir = 0; cfg_deadtime = 0;
        cfg_period = 8'd9; cfg_duty = 8'd4;
        step(3);
        rst = 0;
        step(1);
        chk("R1 oe", pwm_oe, 4'b0000);
        chk("R1 out", pwm_out, 4'b0000);
        chk("R1 flag", {3'b0, roll_flag}, 4'b0000);
        chk("R10 idle", pwm_out, 4'b0000);
    endtask

    task automatic t_startup();
        mode_en = 1; drv_req = 1;
        #0.5;
        chk("R3 fwd cnt0", pwm_out, pinv(4'b1001));
        step(9);                                   // cnt = 9
        chk("R6 oe held", pwm_oe, 4'b0000);
        chk("R7 flag clear before wrap", {3'b0, roll_flag}, 4'b0000);
        step(1);                                   // cnt = 0 after wrap
        chk("R6 oe on", pwm_oe, 4'b1111);
        chk("R7 flag set", {3'b0, roll_flag}, 4'b0001);
    endtask

    task automatic t_modulate();
        step(3);                                   // cnt = 3
        chk("R2 below duty", pwm_out, pinv(4'b1001));
        step(1);                                   // cnt = 4
        chk("R2 at duty", pwm_out, pinv(4'b0001));
        roll_clr = 1;
        step(1);                                   // cnt = 5
        roll_clr = 0;
        chk("R7 cleared", {3'b0, roll_flag}, 4'b0000);
        step(5);                                   // cnt = 0
        chk("R7 set again", {3'b0, roll_flag}, 4'b0001);
    endtask

    task automatic t_polarity();
        pol_ac = 1; pol_bd = 1; pol_wr = 1;
        step(1);                                   // cnt = 1
        pol_wr = 0;
        chk("R5 write ignored", pwm_out, 4'b1001);
        drv_req = 0;
        #0.5;
        chk("R8 oe drops now", pwm_oe, 4'b0000);
        pol_wr = 1;
        step(1);                                   // cnt = 2
        pol_wr = 0;
        m_ac = 1; m_bd = 1;
        chk("R4 inverted", pwm_out, 4'b0110);
        drv_req = 1;
        step(7);                                   // cnt = 9
        chk("R8 rearmed", pwm_oe, 4'b0000);
        step(1);                                   // cnt = 0
        chk("R8 back on", pwm_oe, 4'b1111);
    endtask

    task automatic t_duty_limits();
        cfg_duty = 8'd0;
        #0.5;
        chk("R2 duty zero", pwm_out, pinv(4'b0001));
        cfg_duty = 8'd10;
        step(9);                                   // cnt = 9
        chk("R2 duty above period", pwm_out, pinv(4'b1001));
        step(1);                                   // cnt = 0
    endtask

    task automatic t_direction();
        cfg_duty = 8'd4; cfg_deadtime = 4'd3; cfg_dir = 1;
        #0.5;
        chk("R9 no change mid period", pwm_out, pinv(4'b1001));
        step(9);                                   // cnt = 9
        chk("R9 still forward", pwm_out, pinv(4'b0001));
        step(1);                                   // wrap, dead = 3
        chk("R9 dead start", pwm_out, pinv(4'b0000));
        step(2);                                   // dead = 1
        chk("R9 dead end", pwm_out, pinv(4'b0000));
        step(1);                                   // cnt = 3, dead = 0
        chk("R3 reverse mod on", pwm_out, pinv(4'b0110));
        step(1);                                   // cnt = 4
        chk("R3 reverse mod off", pwm_out, pinv(4'b0100));
    endtask

    task automatic t_disable();
        mode_en = 0;
        #0.5;
        chk("R10 oe off", pwm_oe, 4'b0000);
        step(1);
        chk("R10 outputs idle", pwm_out, pinv(4'b0000));
    endtask

    initial begin
        t_reset();
        t_startup();
        t_modulate();
        t_polarity();
        t_duty_limits();
        t_direction();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule